// File: doc/BRIEF.md
# Selectable-Polynomial Byte-Serial CRC Accumulator

This unit advances a 32-bit CRC accumulator over 1, 2, 4 or 8 bytes taken from the low end of a 64-bit data word. Either the IEEE CRC-32 polynomial or the Castagnoli (CRC-32C) polynomial can be picked on each operation. The update is the raw reflected form, with no complement of the accumulator on entry or on exit. Software that wants a message-level CRC applies those inversions itself and chains operations by feeding each result back in as the next accumulator.

An operation begins with a one-cycle start strobe while the unit is idle. The unit then folds in one byte per clock and holds busy for as many cycles as there are bytes. It ends with a single-cycle done pulse, and the new accumulator value appears on the result port at the same time. The result then stays there until the next operation completes.

Top module: `crc_accum`

## Requirements
- R1: After reset, busy and done are low and result is zero.
- R2: Each byte is XORed into the low 8 bits of the accumulator, and the accumulator then takes 8 right-shift steps. A step XORs in the reflected polynomial when the bit shifted out is 1. The polynomial is 0xEDB88320 when crc32c_sel is 0 and 0x82F63B78 when crc32c_sel is 1.
- R3: Bytes are used least significant first: byte k is data_in[8k+7:8k]. With a count of 1, 2, 4 or 8, only that many low bytes are used, and the bytes above them have no effect on result.
- R4: Any other byte_count value (0, 3, 5, 6, 7, 9 to 15) is handled as 8.
- R5: When start is accepted, busy is high for exactly N consecutive cycles beginning with the next cycle, where N is the effective byte count.
- R6: done is high for exactly one cycle, in the first cycle after busy falls, and result carries the updated accumulator in that cycle. result holds that value until the next done.
- R7: A start asserted while busy is high is ignored. The running operation's result and timing are unchanged, and no extra done is produced.
- R8: No inversion is applied. A zero accumulator with zero data gives zero. Chained operations reproduce the standard check values (0xCBF43926 for CRC-32, 0xE3069283 for CRC-32C) over the ASCII text "123456789" when software complements the input and the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation; taken only when idle |
| acc_in | input | 32 | Starting accumulator value |
| data_in | input | 64 | Data bytes, least significant byte first |
| byte_count | input | 4 | Bytes to consume: 1, 2, 4 or 8 (other values mean 8) |
| crc32c_sel | input | 1 | 0 selects CRC-32, 1 selects CRC-32C |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Updated accumulator, valid from done onward |

## Verification
The bench chains a nine-byte message as eight bytes followed by one byte under each polynomial and compares the result against the published check values. A design that shifted the wrong way, took the bytes in the wrong order or swapped the polynomials would miss those constants. It also loads bytes with nonzero data above the selected count. A design that took in those bytes would return a different CRC. Illegal count codes must give the eight-cycle busy window and the eight-byte result, not a short or stuck run. A start pulsed in the middle of an operation, including during a one-byte operation, must not disturb the result or add a second done pulse. A design that restarted on it would show a wrong value or an unexpected extra result.

// File: rtl/crc_accum.sv
module crc_accum #(
  parameter int          DATA_W   = 64,
  parameter int          CRC_W    = 32,
  parameter int          CNT_W    = 4,
  parameter logic [31:0] POLY_STD = 32'hEDB88320,
  parameter logic [31:0] POLY_CAS = 32'h82F63B78
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CRC_W-1:0]  acc_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic              crc32c_sel,
  output logic              busy,
  output logic              done,
  output logic [CRC_W-1:0]  result
);
  localparam int LANES = DATA_W / 8;

  logic [CRC_W-1:0]  crc_q, res_q, poly_q;
  logic [DATA_W-1:0] dat_q;
  logic [CNT_W-1:0]  left_q, eff_cnt;
  logic              busy_q, done_q;
  logic [CRC_W-1:0]  crc_nxt;

  function automatic logic [CRC_W-1:0] fold_byte(input logic [CRC_W-1:0] c_in,
                                                 input logic [7:0] b,
                                                 input logic [CRC_W-1:0] p);
    logic [CRC_W-1:0] c;
    c = c_in ^ {{(CRC_W-8){1'b0}}, b};
    for (int i = 0; i < 8; i++)
      c = c[0] ? ((c >> 1) ^ p) : (c >> 1);
    return c;
  endfunction

  always_comb begin
    eff_cnt = CNT_W'(LANES);
    for (int k = 1; k < LANES; k = k * 2)
      if (byte_count == CNT_W'(k)) eff_cnt = CNT_W'(k);
  end

  assign crc_nxt = fold_byte(crc_q, dat_q[7:0], poly_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q  <= '0;
      res_q  <= '0;
      poly_q <= '0;
      dat_q  <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        crc_q  <= crc_nxt;
        dat_q  <= dat_q >> 8;
        left_q <= left_q - 1'b1;
        if (left_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          res_q  <= crc_nxt;
        end
      end else if (start) begin
        crc_q  <= acc_in;
        dat_q  <= data_in;
        left_q <= eff_cnt;
        poly_q <= crc32c_sel ? CRC_W'(POLY_CAS) : CRC_W'(POLY_STD);
        busy_q <= 1'b1;
      end
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign result = res_q;
endmodule

// File: rtl/crc_accum_chk.sv
module crc_accum_chk #(
  parameter int CRC_W = 32,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [CNT_W-1:0] byte_count,
  input logic             busy,
  input logic             done,
  input logic [CRC_W-1:0] result
);
  logic [CNT_W:0] want_len, seen_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      want_len <= '0;
      seen_len <= '0;
    end else if (start && !busy) begin
      seen_len <= '0;
      case (byte_count)
        4'd1:    want_len <= 5'd1;
        4'd2:    want_len <= 5'd2;
        4'd4:    want_len <= 5'd4;
        default: want_len <= 5'd8;
      endcase
    end else if (busy) begin
      seen_len <= seen_len + 1'b1;
    end
  end

  // R5
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> seen_len == want_len);
  // R5
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
  // R7
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> (busy || done));
endmodule

bind crc_accum crc_accum_chk #(.CRC_W(CRC_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
  .busy(busy), .done(done), .result(result)
);

// File: tb/tb_crc_accum.sv
`timescale 1ns/1ps
module tb_crc_accum;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] acc_in = '0;
  logic [63:0] data_in = '0;
  logic [3:0]  byte_count = 4'd1;
  logic        crc32c_sel = 1'b0;
  logic        busy, done;
  logic [31:0] result;

  int checks = 0, errors = 0, pushes = 0, dones = 0, cycles = 0;
  logic [31:0] expq[$];
  logic        finished = 1'b0;

  always #4 clk = ~clk;

  crc_accum dut (.clk(clk), .rst_n(rst_n), .start(start), .acc_in(acc_in),
    .data_in(data_in), .byte_count(byte_count), .crc32c_sel(crc32c_sel),
    .busy(busy), .done(done), .result(result));

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int eff_len(input logic [3:0] n);
    if (n == 4'd1 || n == 4'd2 || n == 4'd4) return int'(n);
    return 8;
  endfunction

  function automatic logic [31:0] ref_crc(input logic [31:0] acc, input logic [63:0] d,
                                         input int n, input bit cas);
    logic [31:0] c, p;
    p = cas ? 32'h82F63B78 : 32'hEDB88320;
    c = acc;
    for (int k = 0; k < n; k++) begin
      c = c ^ {24'h0, d[8*k +: 8]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ p) : (c >> 1);
    end
    return c;
  endfunction

  always @(negedge clk) begin
    if (rst_n && done) begin
      dones++;
      if (expq.size() == 0) check(1'b0, "R7 unexpected done", {32'h0, result}, 64'h0);
      else begin
        logic [31:0] e;
        e = expq.pop_front();
        check(result == e, "R2/R3 result", {32'h0, result}, {32'h0, e});
      end
    end
  end

  task automatic run_op(input logic [31:0] acc, input logic [63:0] d, input logic [3:0] n,
                        input bit cas, input bit inject, output logic [31:0] got);
    int len, cyc;
    len = eff_len(n);
    expq.push_back(ref_crc(acc, d, len, cas));
    pushes++;
    @(negedge clk);
    start = 1'b1; acc_in = acc; data_in = d; byte_count = n; crc32c_sel = cas;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (busy && cyc < 20) begin
      cyc++;
      if (inject && cyc == 1) begin
        start = 1'b1; acc_in = ~acc; data_in = ~d; byte_count = 4'd1; crc32c_sel = ~cas;
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    check(cyc == len, "R5 busy length", 64'(cyc), 64'(len));
    check(done == 1'b1, "R6 done after busy", {63'h0, done}, 64'h1);
    got = result;
    @(negedge clk);
    check(done == 1'b0, "R6 done one cycle", {63'h0, done}, 64'h0);
    check(result == got, "R6 result held", {32'h0, result}, {32'h0, got});
    if (inject) check(busy == 1'b0, "R7 no restart", {63'h0, busy}, 64'h0);
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    // R1
    check(busy == 1'b0, "R1 busy reset", {63'h0, busy}, 64'h0);
    check(done == 1'b0, "R1 done reset", {63'h0, done}, 64'h0);
    check(result == 32'h0, "R1 result reset", {32'h0, result}, 64'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R8: zero in, zero out
    run_op(32'h0, 64'h0, 4'd8, 1'b0, 1'b0, r);
    check(r == 32'h0, "R8 zero", {32'h0, r}, 64'h0);

    // R8, R2, R3: check values for both polynomials
    run_op(32'hFFFFFFFF, 64'h3837363534333231, 4'd8, 1'b0, 1'b0, r);
    run_op(r, 64'h39, 4'd1, 1'b0, 1'b0, r);
    check((r ^ 32'hFFFFFFFF) == 32'hCBF43926, "R8 crc32 check", {32'h0, r ^ 32'hFFFFFFFF}, 64'hCBF43926);
    run_op(32'hFFFFFFFF, 64'h3837363534333231, 4'd8, 1'b1, 1'b0, r);
    run_op(r, 64'h39, 4'd1, 1'b1, 1'b0, r);
    check((r ^ 32'hFFFFFFFF) == 32'hE3069283, "R8 crc32c check", {32'h0, r ^ 32'hFFFFFFFF}, 64'hE3069283);

    // R3: upper bytes ignored, counts 1 2 4
    run_op(32'h12345678, 64'hDEADBEEFCAFEF0A5, 4'd1, 1'b0, 1'b0, r);
    check(r == ref_crc(32'h12345678, 64'hA5, 1, 1'b0), "R3 count1 upper ignored", {32'h0, r}, {32'h0, ref_crc(32'h12345678, 64'hA5, 1, 1'b0)});
    run_op(32'h0BADF00D, 64'hFFFFFFFFFFFF1234, 4'd2, 1'b1, 1'b0, r);
    check(r == ref_crc(32'h0BADF00D, 64'h1234, 2, 1'b1), "R3 count2 upper ignored", {32'h0, r}, {32'h0, ref_crc(32'h0BADF00D, 64'h1234, 2, 1'b1)});
    run_op(32'hA5A5A5A5, 64'h0123456789ABCDEF, 4'd4, 1'b0, 1'b0, r);

    // R4: illegal counts act as 8
    run_op(32'h11112222, 64'h0123456789ABCDEF, 4'd0, 1'b1, 1'b0, r);
    run_op(32'h33334444, 64'hFEDCBA9876543210, 4'd3, 1'b0, 1'b0, r);
    run_op(32'h55556666, 64'h1122334455667788, 4'd15, 1'b1, 1'b0, r);
    check(r == ref_crc(32'h55556666, 64'h1122334455667788, 8, 1'b1), "R4 count15 as 8", {32'h0, r}, {32'h0, ref_crc(32'h55556666, 64'h1122334455667788, 8, 1'b1)});

    // R7: start during busy is ignored
    run_op(32'hCAFEBABE, 64'h8877665544332211, 4'd4, 1'b0, 1'b1, r);
    run_op(32'h76543210, 64'h00000000000000C3, 4'd1, 1'b1, 1'b1, r);
    run_op(32'h0F0F0F0F, 64'h5A5A5A5A5A5A5A5A, 4'd8, 1'b1, 1'b1, r);

    repeat (4) @(negedge clk);
    check(expq.size() == 0, "R7 all results seen", 64'(expq.size()), 64'h0);
    check(dones == pushes, "R7 done count", 64'(dones), 64'(pushes));
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule